// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Address Hold

A synchronous two-port memory with one shared clock. Both ports are symmetrical and can read or write any word. Each port has an address, write data, a write strobe, a read strobe, per-lane write enables and a hold input. While the hold input is high, the port keeps reusing the address it latched earlier.

All port inputs are registered on the rising edge. The memory access happens on the next edge, and the read result is captured into an output register on that same edge. A read issued at one edge therefore shows at the output after the following edge.

Parameters select the read-during-write result separately for each port's own writes (new or old data) and for a write made by the opposite port (old data by default). A further parameter sets what a masked lane shows in new-data mode. A flag marks a same-word write collision between the ports.

Top module: `tdp_ram_hold`

## Requirements
- R1: A read captured at edge k shows on that port's read data after edge k+1 and not earlier.
- R2: While a port's hold input is high at a capturing edge, that port keeps its previously latched address for both reads and writes; the two ports hold independently.
- R3: Write-enable bit i gates data bits [i*BYTE_W +: BYTE_W]; bit 0 is the least-significant lane. A disabled lane keeps its stored value.
- R4: With its read strobe low, a port's read data keeps its last value, even while that port writes.
- R5: A port in new-data mode (encoding 1) that reads and writes in one access outputs the written lanes merged with the stored content of the disabled lanes, when MASK_ZERO is 0.
- R6: A port in old-data mode (encoding 0) that reads and writes in one access outputs the word as it was before the write.
- R7: With the mixed-port mode at old data (encoding 0), a port reading a word that the other port writes in the same access returns the contents from before the write.
- R8: With MASK_ZERO set to 1, a disabled lane in a new-data same-port access reads as zero.
- R9: When both ports write the same word in the same access, `collide` is high for exactly one cycle, aligned with the read data of that access, and port A's enabled lanes are stored.
- R10: A low `rst_n` at a clock edge clears both read data outputs and `collide`, and it cancels any write that was captured before that edge. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_addr | input | AW | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_we | input | 1 | Port A write strobe |
| a_re | input | 1 | Port A read strobe |
| a_be | input | LANES | Port A lane write enables |
| a_hold | input | 1 | Port A address hold |
| a_rdata | output | WIDTH | Port A registered read data |
| b_addr | input | AW | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_we | input | 1 | Port B write strobe |
| b_re | input | 1 | Port B read strobe |
| b_be | input | LANES | Port B lane write enables |
| b_hold | input | 1 | Port B address hold |
| b_rdata | output | WIDTH | Port B registered read data |
| collide | output | 1 | Same-word dual-write indicator |

## Verification
The bench builds the main instance with 16 words of 16 bits and two 8-bit lanes. Port A is set to new data, port B to old data, and the mixed-port mode to old data, so that one run covers both same-port policies and the cross-port case. A second instance differs only in MASK_ZERO=1 and receives the same stimulus, which puts the zeroed masked lane within reach. Two lanes are enough to exercise a partial write against a retained lane in both bit orders.

// File: rtl/tdp_ram_pkg.sv
// Shared types for the dual-port RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package tdp_ram_pkg;
    // Read-during-write result selector
    typedef enum logic {
        RDW_OLD = 1'b0,
        RDW_NEW = 1'b1
    } rdw_e;
endpackage

// File: rtl/tdp_port_capture.sv
// Input register stage for one RAM port. It latches the address unless
// hold is high, and latches data, strobes and lane enables every cycle.
// Assumes: synchronous active-low reset clears the strobes.
module tdp_port_capture #(
    parameter int AW    = 4,
    parameter int WIDTH = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             we,
    input  logic             re,
    input  logic [LANES-1:0] be,
    input  logic             hold,
    output logic [AW-1:0]    addr_q,
    output logic [WIDTH-1:0] wdata_q,
    output logic             we_q,
    output logic             re_q,
    output logic [LANES-1:0] be_q
);

    // Address register: keeps the old address while hold is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!hold) begin
            addr_q <= addr;
        end
    end

    // Data, strobe and lane-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            we_q    <= 1'b0;
            re_q    <= 1'b0;
            be_q    <= '0;
        end else begin
            wdata_q <= wdata;
            we_q    <= we;
            re_q    <= re;
            be_q    <= be;
        end
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(addr_q));

endmodule

// File: rtl/tdp_store.sv
// Word storage with two lane-masked write ports and two asynchronous
// read taps. On a same-word collision port A's lanes are written last.
// Assumes: writes are suppressed while rst_n is low; contents are not reset.
module tdp_store #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 16,
    parameter int BYTE_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LANES = WIDTH / BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] data_a,
    input  logic             we_a,
    input  logic [LANES-1:0] be_a,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] data_b,
    input  logic             we_b,
    input  logic [LANES-1:0] be_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Lane writes: port B first, port A afterwards so A wins a collision
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                if (we_b && be_b[l]) begin
                    mem_q[addr_b][l*BYTE_W +: BYTE_W] <= data_b[l*BYTE_W +: BYTE_W];
                end
            end
            for (int l = 0; l < LANES; l++) begin
                if (we_a && be_a[l]) begin
                    mem_q[addr_a][l*BYTE_W +: BYTE_W] <= data_a[l*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Read taps of the current contents
    assign rd_a = mem_q[addr_a];
    assign rd_b = mem_q[addr_b];

    // R9
    collide_a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b && (addr_a == addr_b) && (&be_a))
        |=> mem_q[$past(addr_a)] == $past(data_a));

endmodule

// File: rtl/tdp_read_path.sv
// Output side of one port: builds the read word from the stored word and
// any write in the same access, then registers it when the read strobe is set.
// Assumes: own-port policy takes priority over the other port's write.
module tdp_read_path
    import tdp_ram_pkg::*;
#(
    parameter int   WIDTH     = 16,
    parameter int   BYTE_W    = 8,
    parameter rdw_e SAME_MODE = RDW_NEW,
    parameter rdw_e MIX_MODE  = RDW_OLD,
    parameter bit   MASK_ZERO = 1'b0,
    localparam int  LANES     = WIDTH / BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re_q,
    input  logic [WIDTH-1:0] stored,
    input  logic             own_we,
    input  logic [WIDTH-1:0] own_data,
    input  logic [LANES-1:0] own_be,
    input  logic             oth_we,
    input  logic [WIDTH-1:0] oth_data,
    input  logic [LANES-1:0] oth_be,
    input  logic             oth_hit,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] next_word;
    logic             own_new;
    logic             oth_new;

    assign own_new = (SAME_MODE == RDW_NEW) && own_we;
    assign oth_new = (MIX_MODE == RDW_NEW) && oth_we && oth_hit;

    // Lane-by-lane selection of the word to present
    always_comb begin
        next_word = stored;
        for (int l = 0; l < LANES; l++) begin
            if (own_new) begin
                if (own_be[l]) begin
                    next_word[l*BYTE_W +: BYTE_W] = own_data[l*BYTE_W +: BYTE_W];
                end else if (MASK_ZERO) begin
                    next_word[l*BYTE_W +: BYTE_W] = '0;
                end
            end else if (oth_new && oth_be[l]) begin
                next_word[l*BYTE_W +: BYTE_W] = oth_data[l*BYTE_W +: BYTE_W];
            end
        end
    end

    // Output register, loaded only on an enabled read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re_q) begin
            rdata <= next_word;
        end
    end

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_q |=> $stable(rdata));

    // R6
    rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re_q && (SAME_MODE == RDW_OLD) && !oth_new) |=> rdata == $past(stored));

endmodule

// File: rtl/tdp_ram_hold.sv
// Top of the dual-port RAM: two input capture stages, the shared storage,
// two read paths and the same-word collision flag.
// Assumes: one clock; WIDTH is a multiple of BYTE_W; BYTE_W is 5, 8, 9 or 10.
module tdp_ram_hold
    import tdp_ram_pkg::*;
#(
    parameter int   DEPTH     = 16,
    parameter int   WIDTH     = 16,
    parameter int   BYTE_W    = 8,
    parameter rdw_e A_SAME    = RDW_NEW,
    parameter rdw_e B_SAME    = RDW_OLD,
    parameter rdw_e MIX_MODE  = RDW_OLD,
    parameter bit   MASK_ZERO = 1'b0,
    localparam int  AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int  LANES     = WIDTH / BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             a_we,
    input  logic             a_re,
    input  logic [LANES-1:0] a_be,
    input  logic             a_hold,
    output logic [WIDTH-1:0] a_rdata,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic             b_we,
    input  logic             b_re,
    input  logic [LANES-1:0] b_be,
    input  logic             b_hold,
    output logic [WIDTH-1:0] b_rdata,
    output logic             collide
);

    logic [AW-1:0]    a_addr_q, b_addr_q;
    logic [WIDTH-1:0] a_data_q, b_data_q;
    logic             a_we_q, b_we_q, a_re_q, b_re_q;
    logic [LANES-1:0] a_be_q, b_be_q;
    logic [WIDTH-1:0] a_stored, b_stored;
    logic             same_word;

    tdp_port_capture #(.AW(AW), .WIDTH(WIDTH), .LANES(LANES)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .addr(a_addr), .wdata(a_wdata), .we(a_we),
        .re(a_re), .be(a_be), .hold(a_hold), .addr_q(a_addr_q),
        .wdata_q(a_data_q), .we_q(a_we_q), .re_q(a_re_q), .be_q(a_be_q)
    );

    tdp_port_capture #(.AW(AW), .WIDTH(WIDTH), .LANES(LANES)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .wdata(b_wdata), .we(b_we),
        .re(b_re), .be(b_be), .hold(b_hold), .addr_q(b_addr_q),
        .wdata_q(b_data_q), .we_q(b_we_q), .re_q(b_re_q), .be_q(b_be_q)
    );

    tdp_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .addr_a(a_addr_q), .data_a(a_data_q), .we_a(a_we_q), .be_a(a_be_q),
        .addr_b(b_addr_q), .data_b(b_data_q), .we_b(b_we_q), .be_b(b_be_q),
        .rd_a(a_stored), .rd_b(b_stored)
    );

    assign same_word = (a_addr_q == b_addr_q);

    tdp_read_path #(.WIDTH(WIDTH), .BYTE_W(BYTE_W), .SAME_MODE(A_SAME),
                    .MIX_MODE(MIX_MODE), .MASK_ZERO(MASK_ZERO)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .re_q(a_re_q), .stored(a_stored),
        .own_we(a_we_q), .own_data(a_data_q), .own_be(a_be_q),
        .oth_we(b_we_q), .oth_data(b_data_q), .oth_be(b_be_q),
        .oth_hit(same_word), .rdata(a_rdata)
    );

    tdp_read_path #(.WIDTH(WIDTH), .BYTE_W(BYTE_W), .SAME_MODE(B_SAME),
                    .MIX_MODE(MIX_MODE), .MASK_ZERO(MASK_ZERO)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .re_q(b_re_q), .stored(b_stored),
        .own_we(b_we_q), .own_data(b_data_q), .own_be(b_be_q),
        .oth_we(a_we_q), .oth_data(a_data_q), .oth_be(a_be_q),
        .oth_hit(same_word), .rdata(b_rdata)
    );

    // Collision flag, aligned with the read data of the colliding access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collide <= 1'b0;
        end else begin
            collide <= a_we_q && b_we_q && same_word;
        end
    end

    // R9
    collide_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> ($past(a_we_q) && $past(b_we_q)));

endmodule

// File: tb/tdp_ram_hold_tb.sv
module tdp_ram_hold_tb;
    import tdp_ram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int WIDTH = 16;
    localparam int BYTE_W = 8;
    localparam int AW = 4;
    localparam int LANES = 2;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [AW-1:0]    aa;
        logic [WIDTH-1:0] ad;
        logic             awe;
        logic             are;
        logic [LANES-1:0] abe;
        logic             ah;
        logic [AW-1:0]    ba;
        logic [WIDTH-1:0] bd;
        logic             bwe;
        logic             bre;
        logic [LANES-1:0] bbe;
        logic             bh;
        logic [WIDTH-1:0] ea;
        logic [WIDTH-1:0] eb;
        logic             ec;
    } vec_t;

    // Each vector: one access per port, then the expected outputs two edges later
    localparam vec_t VEC [NVEC] = '{
        // V0 plain writes, no reads (R3, R4)
        '{4'd1, 16'h1234, 1'b1, 1'b0, 2'b11, 1'b0, 4'd2, 16'hABCD, 1'b1, 1'b0, 2'b11, 1'b0, 16'h0000, 16'h0000, 1'b0},
        // V1 reads back (R1)
        '{4'd1, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 4'd2, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 16'h1234, 16'hABCD, 1'b0},
        // V2 A new-data upper-lane write (R5); B reads same word, old data (R7)
        '{4'd1, 16'h5600, 1'b1, 1'b1, 2'b10, 1'b0, 4'd1, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 16'h5634, 16'h1234, 1'b0},
        // V3 B old-data lower-lane write (R6); A reads same word (R7)
        '{4'd2, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 4'd2, 16'h00EF, 1'b1, 1'b1, 2'b01, 1'b0, 16'hABCD, 16'hABCD, 1'b0},
        // V4 lane retention both orders (R3)
        '{4'd1, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 4'd2, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 16'h5634, 16'hABEF, 1'b0},
        // V5 A writes with read low, output held (R4)
        '{4'd3, 16'h7777, 1'b1, 1'b0, 2'b11, 1'b0, 4'd2, 16'h0000, 1'b0, 1'b0, 2'b11, 1'b0, 16'h5634, 16'hABEF, 1'b0},
        // V6 A held at word 3 while presenting 5 (R2)
        '{4'd5, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b1, 4'd2, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 16'h7777, 16'hABEF, 1'b0},
        // V7 A held write lands in word 3 (R2); B reads word 3 old (R7)
        '{4'd9, 16'h1111, 1'b1, 1'b0, 2'b11, 1'b1, 4'd3, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 16'h7777, 16'h7777, 1'b0},
        // V8 A reads word 3 (R2)
        '{4'd3, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 4'd4, 16'h4444, 1'b1, 1'b0, 2'b11, 1'b0, 16'h1111, 16'h7777, 1'b0},
        // V9 both write word 4 (R9)
        '{4'd4, 16'hAAAA, 1'b1, 1'b0, 2'b11, 1'b0, 4'd4, 16'hBBBB, 1'b1, 1'b0, 2'b11, 1'b0, 16'h1111, 16'h7777, 1'b1},
        // V10 A's data stored, flag gone (R9)
        '{4'd4, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 4'd4, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 16'hAAAA, 16'hAAAA, 1'b0},
        // V11 B held at word 4, A free (R2)
        '{4'd1, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b0, 4'd7, 16'h0000, 1'b0, 1'b1, 2'b11, 1'b1, 16'h5634, 16'hAAAA, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    a_addr = '0, b_addr = '0;
    logic [WIDTH-1:0] a_wdata = '0, b_wdata = '0;
    logic             a_we = 1'b0, a_re = 1'b0, a_hold = 1'b0;
    logic             b_we = 1'b0, b_re = 1'b0, b_hold = 1'b0;
    logic [LANES-1:0] a_be = '1, b_be = '1;
    logic [WIDTH-1:0] a_rdata, b_rdata, dc_a_rdata, dc_b_rdata;
    logic             collide, dc_collide;
    int               n_chk = 0;
    int               n_fail = 0;
    bit               done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdp_ram_hold #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BYTE_W(BYTE_W), .A_SAME(RDW_NEW),
                   .B_SAME(RDW_OLD), .MIX_MODE(RDW_OLD), .MASK_ZERO(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we),
        .a_re(a_re), .a_be(a_be), .a_hold(a_hold), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .b_be(b_be), .b_hold(b_hold), .b_rdata(b_rdata), .collide(collide)
    );

    tdp_ram_hold #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BYTE_W(BYTE_W), .A_SAME(RDW_NEW),
                   .B_SAME(RDW_OLD), .MIX_MODE(RDW_OLD), .MASK_ZERO(1'b1)) u_dut_dc (
        .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we),
        .a_re(a_re), .a_be(a_be), .a_hold(a_hold), .a_rdata(dc_a_rdata),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re),
        .b_be(b_be), .b_hold(b_hold), .b_rdata(dc_b_rdata), .collide(dc_collide)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R10 reset state
        check("R10 a_rdata reset", a_rdata, 16'h0000);
        check("R10 b_rdata reset", b_rdata, 16'h0000);
        check("R10 collide reset", {15'd0, collide}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            a_addr = VEC[i].aa; a_wdata = VEC[i].ad; a_we = VEC[i].awe;
            a_re = VEC[i].are; a_be = VEC[i].abe; a_hold = VEC[i].ah;
            b_addr = VEC[i].ba; b_wdata = VEC[i].bd; b_we = VEC[i].bwe;
            b_re = VEC[i].bre; b_be = VEC[i].bbe; b_hold = VEC[i].bh;
            tick();
            a_we = 1'b0; a_re = 1'b0; b_we = 1'b0; b_re = 1'b0;
            tick();
            check($sformatf("vector %0d port A (R1..R9)", i), a_rdata, VEC[i].ea);
            check($sformatf("vector %0d port B (R1..R9)", i), b_rdata, VEC[i].eb);
            check($sformatf("vector %0d collide R9", i), {15'd0, collide}, {15'd0, VEC[i].ec});
            if (i == 2) begin
                // R8 masked lane reads as zero
                check("R8 masked lane zero", dc_a_rdata, 16'h5600);
            end
        end

        // R1 latency: not visible after one edge
        a_hold = 1'b0; b_hold = 1'b0;
        a_addr = 4'd3; a_re = 1'b1;
        tick();
        a_re = 1'b0;
        check("R1 not yet updated", a_rdata, 16'h5634);
        tick();
        check("R1 updated after second edge", a_rdata, 16'h1111);

        // R10 captured write is cancelled by reset
        a_addr = 4'd1; a_wdata = 16'hDEAD; a_we = 1'b1; a_be = 2'b11;
        tick();
        a_we = 1'b0; rst_n = 1'b0;
        tick();
        check("R10 a_rdata cleared", a_rdata, 16'h0000);
        check("R10 b_rdata cleared", b_rdata, 16'h0000);
        rst_n = 1'b1;
        a_re = 1'b1;
        tick();
        a_re = 1'b0;
        tick();
        check("R10 write cancelled", a_rdata, 16'h5634);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule